// File: doc/BRIEF.md
# Companding PCM Code Formatter

This block converts between signed linear audio samples and 8-bit companded PCM code words. It supports both the 13-bit A-law scale and the 14-bit µ-law scale, chosen by a static law input. On the encode side, a linear sample enters with a valid strobe, and the line-ready code word appears one clock later with its own valid flag. For A-law, the even-position bits are already inverted as the line expects. On the decode side, a received code word is expanded to the midpoint of its quantization step, also with one cycle of latency.

Both laws use one shared datapath shape: the sign is folded into a magnitude, a segment (chord) search picks one of eight exponent ranges, and a 4-bit step is taken from just below the leading one. The law input selects the bias, the clipping, and the output bit mask. The two directions are independent and can run in the same cycle.

Top module: `pcm_compander`

## Requirements
- R1: `law_mu` = 0 selects A-law and `law_mu` = 1 selects µ-law. Each direction is registered. `enc_valid_o` equals `enc_valid_i` of the previous clock, and `dec_valid_o` equals `dec_valid_i` of the previous clock.
- R2: A code word is laid out as bit 7 = sign (1 for a non-negative sample), bits 6:4 = segment and bits 3:0 = step, before any line mask is applied. Bit 7 is the bit sent first on a serial line.
- R3: In A-law mode, the 13-bit two's-complement sample sits in `enc_sample_i[13:1]` and bit 0 is ignored. The magnitude is s for s ≥ 0 and ~s otherwise. Segment 0 is linear: step = mag[4:1]. Segment k ≥ 1 covers mag in [16·2^k, 32·2^k) with step = (mag >> k) & 15. The word is XORed with 8'h55 before output.
- R4: A-law fixed points: the most positive sample gives 8'hAA, the most negative gives 8'h2A, zero gives 8'hD5, and -1 gives 8'h55.
- R5: In µ-law mode, the 14-bit magnitude (s, or ~s when negative) is clipped at 8158 and then biased by +33. Segment k covers the biased value b in [32·2^k, 64·2^k) with step = (b >> (k+1)) & 15. The output is {sign, ~segment, ~step}.
- R6: µ-law fixed points: the most positive sample gives 8'h80, the most negative gives 8'h00, zero gives 8'hFF, and -1 gives 8'h7F.
- R7: In µ-law mode, every magnitude above 8158 encodes the same as 8158. Both +8191 and -8192 map to the full-scale code of their sign.
- R8: A-law decode restores the 13-bit value at the step midpoint. For segment 0 this is 2·step+1. For segment k ≥ 1 it is (16+step)·2^k + 2^(k-1). The result is negated as ~mag when the sign bit is 0 and placed in `dec_sample_o[13:1]` with bit 0 = 0.
- R9: µ-law decode produces mag = ((2·step+33) << segment) − 33 after inverting the code. The output is mag when the sign is 1 and ~mag otherwise, in 14 bits.
- R10: For each law, encoding the decoded value of any of the 256 code words returns that same code word.
- R11: While an input valid is low, the matching output data register holds its previous value, whatever the data input does.
- R12: After reset, both valid outputs, `enc_code_o` and `dec_sample_o`, are all zero until the first accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| law_mu | input | 1 | Law select: 0 A-law, 1 µ-law (static) |
| enc_valid_i | input | 1 | Linear sample strobe |
| enc_sample_i | input | 14 | Two's-complement linear sample |
| dec_valid_i | input | 1 | Code word strobe |
| dec_code_i | input | 8 | Received code word |
| enc_valid_o | output | 1 | Encoded code valid |
| enc_code_o | output | 8 | Line-ready code word |
| dec_valid_o | output | 1 | Decoded sample valid |
| dec_sample_o | output | 14 | Expanded linear sample |

## Verification
The bench targets the boundaries of the segments and the sign:
- Zero and -1 must give the two distinct zero codes. A design that folded the sign with true negation would send -1 to a step-1 code.
- Samples of 31 and 32 straddle the A-law linear segment. An off-by-one shift there corrupts the step.
- The µ-law extremes check clipping. A missing clip would wrap the biased magnitude to a small code.
- A-law bit 0 is toggled to prove it is ignored.
- The exhaustive decode-then-encode pass over both laws catches a wrong midpoint, bias, or line mask on any code word.

// File: rtl/pcm_cmp_pkg.sv
package pcm_cmp_pkg;

    localparam int SAMPLE_W  = 14;
    localparam int CODE_W    = 8;
    localparam int SEG_W     = 3;
    localparam int STEP_W    = 4;
    localparam int A_LIN_W   = SAMPLE_W - 1;
    localparam int A_MAG_W   = A_LIN_W - 1;
    localparam int MU_MAG_W  = SAMPLE_W - 1;
    localparam int A_BASE    = 4;
    localparam int MU_BASE   = 5;

    localparam logic [CODE_W-1:0]   A_LINE_MASK = 8'h55;
    localparam logic [MU_MAG_W-1:0] MU_CLIP     = 13'd8158;
    localparam logic [MU_MAG_W-1:0] MU_BIAS     = 13'd33;

    typedef enum logic {
        LAW_A  = 1'b0,
        LAW_MU = 1'b1
    } law_e;

    typedef struct packed {
        logic              pos;
        logic [SEG_W-1:0]  seg;
        logic [STEP_W-1:0] step;
    } code_fields_t;

    function automatic logic [CODE_W-1:0] a_to_line(input code_fields_t f);
        return f ^ A_LINE_MASK;
    endfunction

    function automatic logic [CODE_W-1:0] mu_to_line(input code_fields_t f);
        return {f.pos, ~f.seg, ~f.step};
    endfunction

    function automatic code_fields_t a_from_line(input logic [CODE_W-1:0] c);
        return code_fields_t'(c ^ A_LINE_MASK);
    endfunction

    function automatic code_fields_t mu_from_line(input logic [CODE_W-1:0] c);
        return code_fields_t'({c[CODE_W-1], ~c[CODE_W-2:0]});
    endfunction

endpackage

// File: rtl/pcm_chord_find.sv
module pcm_chord_find #(
    parameter int VAL_W        = 13,
    parameter int BASE         = 5,
    parameter bit LINEAR_FIRST = 1'b0
) (
    input  logic [VAL_W-1:0]                 val,
    output logic [pcm_cmp_pkg::SEG_W-1:0]    seg,
    output logic [pcm_cmp_pkg::STEP_W-1:0]   step
);
    import pcm_cmp_pkg::*;

    localparam int NSEG = 1 << SEG_W;

    logic [VAL_W-1:0] shifted;
    int               sh;

    always_comb begin
        seg = '0;
        for (int k = 1; k < NSEG; k++) begin
            if (val[BASE + k]) seg = SEG_W'(k);
        end
    end

    always_comb begin
        sh = int'(seg) + BASE - 4;
        if (LINEAR_FIRST && seg == '0) sh = sh + 1;
        shifted = val >> sh;
        step    = shifted[STEP_W-1:0];
    end

endmodule

// File: rtl/pcm_lin_to_code.sv
module pcm_lin_to_code (
    input  pcm_cmp_pkg::law_e                    law,
    input  logic [pcm_cmp_pkg::SAMPLE_W-1:0]     sample,
    output logic [pcm_cmp_pkg::CODE_W-1:0]       code
);
    import pcm_cmp_pkg::*;

    logic [A_LIN_W-1:0]  a_lin;
    logic                a_neg;
    logic [A_MAG_W-1:0]  a_mag;
    code_fields_t        a_f;
    logic                unused_a_lsb;

    logic                mu_neg;
    logic [MU_MAG_W-1:0] mu_mag;
    logic [MU_MAG_W-1:0] mu_clip;
    logic [MU_MAG_W-1:0] mu_biased;
    code_fields_t        mu_f;

    assign a_lin        = sample[SAMPLE_W-1:1];
    assign unused_a_lsb = sample[0];
    assign a_neg        = a_lin[A_LIN_W-1];
    assign a_mag        = a_neg ? ~a_lin[A_MAG_W-1:0] : a_lin[A_MAG_W-1:0];

    pcm_chord_find #(
        .VAL_W(A_MAG_W), .BASE(A_BASE), .LINEAR_FIRST(1'b1)
    ) a_chord_i (
        .val(a_mag), .seg(a_f.seg), .step(a_f.step)
    );
    assign a_f.pos = ~a_neg;

    assign mu_neg    = sample[SAMPLE_W-1];
    assign mu_mag    = mu_neg ? ~sample[MU_MAG_W-1:0] : sample[MU_MAG_W-1:0];
    assign mu_clip   = (mu_mag > MU_CLIP) ? MU_CLIP : mu_mag;
    assign mu_biased = mu_clip + MU_BIAS;

    pcm_chord_find #(
        .VAL_W(MU_MAG_W), .BASE(MU_BASE), .LINEAR_FIRST(1'b0)
    ) mu_chord_i (
        .val(mu_biased), .seg(mu_f.seg), .step(mu_f.step)
    );
    assign mu_f.pos = ~mu_neg;

    assign code = (law == LAW_MU) ? mu_to_line(mu_f) : a_to_line(a_f);

endmodule

// File: rtl/pcm_code_to_lin.sv
module pcm_code_to_lin (
    input  pcm_cmp_pkg::law_e                    law,
    input  logic [pcm_cmp_pkg::CODE_W-1:0]       code,
    output logic [pcm_cmp_pkg::SAMPLE_W-1:0]     sample
);
    import pcm_cmp_pkg::*;

    code_fields_t        a_f;
    logic [A_MAG_W-1:0]  a_mag;
    logic [A_LIN_W-1:0]  a_lin;

    code_fields_t        mu_f;
    logic [MU_MAG_W-1:0] mu_b;
    logic [MU_MAG_W-1:0] mu_mag;
    logic [SAMPLE_W-1:0] mu_lin;

    assign a_f  = a_from_line(code);
    assign mu_f = mu_from_line(code);

    always_comb begin
        if (a_f.seg == '0) begin
            a_mag = {{(A_MAG_W-STEP_W-1){1'b0}}, a_f.step, 1'b1};
        end else begin
            a_mag = (A_MAG_W'({1'b1, a_f.step}) << a_f.seg)
                  | (A_MAG_W'(1) << (a_f.seg - SEG_W'(1)));
        end
    end

    assign a_lin  = a_f.pos ? {1'b0, a_mag} : ~{1'b0, a_mag};

    assign mu_b   = MU_MAG_W'({1'b1, mu_f.step, 1'b1}) << mu_f.seg;
    assign mu_mag = mu_b - MU_BIAS;
    assign mu_lin = mu_f.pos ? {1'b0, mu_mag} : ~{1'b0, mu_mag};

    assign sample = (law == LAW_MU) ? mu_lin : {a_lin, 1'b0};

endmodule

// File: rtl/pcm_compander.sv
module pcm_compander (
    input  logic        clk,
    input  logic        rst,
    input  logic        law_mu,
    input  logic        enc_valid_i,
    input  logic [13:0] enc_sample_i,
    input  logic        dec_valid_i,
    input  logic [7:0]  dec_code_i,
    output logic        enc_valid_o,
    output logic [7:0]  enc_code_o,
    output logic        dec_valid_o,
    output logic [13:0] dec_sample_o
);
    import pcm_cmp_pkg::*;

    law_e                law;
    logic [CODE_W-1:0]   enc_code_d;
    logic [SAMPLE_W-1:0] dec_sample_d;

    assign law = law_e'(law_mu);

    pcm_lin_to_code enc_i (
        .law(law), .sample(enc_sample_i), .code(enc_code_d)
    );

    pcm_code_to_lin dec_i (
        .law(law), .code(dec_code_i), .sample(dec_sample_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_valid_o  <= 1'b0;
            enc_code_o   <= '0;
            dec_valid_o  <= 1'b0;
            dec_sample_o <= '0;
        end else begin
            enc_valid_o <= enc_valid_i;
            dec_valid_o <= dec_valid_i;
            if (enc_valid_i) enc_code_o   <= enc_code_d;
            if (dec_valid_i) dec_sample_o <= dec_sample_d;
        end
    end

endmodule

// File: rtl/pcm_compander_chk.sv
module pcm_compander_chk (
    input logic        clk,
    input logic        rst,
    input logic        law_mu,
    input logic        enc_valid_i,
    input logic [13:0] enc_sample_i,
    input logic        dec_valid_i,
    input logic        dec_code_sign,
    input logic        enc_valid_o,
    input logic [7:0]  enc_code_o,
    input logic        dec_valid_o,
    input logic        dec_sample_sign,
    input logic        dec_sample_lsb
);

    AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        enc_valid_i |=> enc_valid_o);                                         // R1
    AST_ENC_IDLE: assert property (@(posedge clk) disable iff (rst)
        !enc_valid_i |=> !enc_valid_o);                                       // R1
    AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        dec_valid_i |=> dec_valid_o);                                         // R1
    AST_ENC_SIGN: assert property (@(posedge clk) disable iff (rst)
        enc_valid_i |=> (enc_code_o[7] == !$past(enc_sample_i[13])));         // R2
    AST_DEC_SIGN: assert property (@(posedge clk) disable iff (rst)
        dec_valid_i |=> (dec_sample_sign == !$past(dec_code_sign)));          // R2
    AST_A_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_i && !law_mu) |=> !dec_sample_lsb);                        // R8
    AST_MU_NEG_CLIP: assert property (@(posedge clk) disable iff (rst)
        (enc_valid_i && law_mu && enc_sample_i == 14'h2000) |=> (enc_code_o == 8'h00)); // R7
    AST_ENC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !enc_valid_i |=> $stable(enc_code_o));                                // R11

endmodule

bind pcm_compander pcm_compander_chk chk_i (
    .clk(clk),
    .rst(rst),
    .law_mu(law_mu),
    .enc_valid_i(enc_valid_i),
    .enc_sample_i(enc_sample_i),
    .dec_valid_i(dec_valid_i),
    .dec_code_sign(dec_code_i[7]),
    .enc_valid_o(enc_valid_o),
    .enc_code_o(enc_code_o),
    .dec_valid_o(dec_valid_o),
    .dec_sample_sign(dec_sample_o[13]),
    .dec_sample_lsb(dec_sample_o[0])
);

// File: tb/pcm_compander_tb_top.sv
module pcm_compander_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        law_mu = 1'b0;
    logic        enc_valid_i = 1'b0;
    logic [13:0] enc_sample_i = '0;
    logic        dec_valid_i = 1'b0;
    logic [7:0]  dec_code_i = '0;
    logic        enc_valid_o;
    logic [7:0]  enc_code_o;
    logic        dec_valid_o;
    logic [13:0] dec_sample_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pcm_compander dut_i (
        .clk(clk), .rst(rst), .law_mu(law_mu),
        .enc_valid_i(enc_valid_i), .enc_sample_i(enc_sample_i),
        .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
        .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
        .dec_valid_o(dec_valid_o), .dec_sample_o(dec_sample_o)
    );

    // {law_mu, sample, expected code}
    localparam logic [22:0] VECS [0:15] = '{
        {1'b0, 14'h0000, 8'hD5},   // R4 zero
        {1'b0, 14'h3FFE, 8'h55},   // R4 minus one
        {1'b0, 14'h1FFE, 8'hAA},   // R4 +full scale
        {1'b0, 14'h2000, 8'h2A},   // R4 -full scale
        {1'b0, 14'h003E, 8'hDA},   // R3 top of linear segment
        {1'b0, 14'h003F, 8'hDA},   // R3 bit 0 ignored
        {1'b0, 14'h0040, 8'hC5},   // R3 first step of segment 1
        {1'b0, 14'h3F38, 8'h7D},   // R3 negative, segment 2
        {1'b1, 14'h0000, 8'hFF},   // R6 zero
        {1'b1, 14'h3FFF, 8'h7F},   // R6 minus one
        {1'b1, 14'h1FDE, 8'h80},   // R6 +full scale at clip point
        {1'b1, 14'h1FFF, 8'h80},   // R7 positive beyond clip
        {1'b1, 14'h2000, 8'h00},   // R7 negative beyond clip
        {1'b1, 14'h0064, 8'hDF},   // R5 positive, segment 2
        {1'b1, 14'h3F9C, 8'h5F},   // R5 negative, segment 2
        {1'b1, 14'h001E, 8'hF0}    // R5 segment 0, last step
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic enc_apply(input logic mu, input logic [13:0] s);
        law_mu       = mu;
        enc_sample_i = s;
        enc_valid_i  = 1'b1;
        @(negedge clk);
        enc_valid_i  = 1'b0;
    endtask

    task automatic dec_apply(input logic mu, input logic [7:0] c);
        law_mu      = mu;
        dec_code_i  = c;
        dec_valid_i = 1'b1;
        @(negedge clk);
        dec_valid_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [7:0]  held;
        logic [13:0] lin;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 enc_valid_o", enc_valid_o, 0);
        check("R12 enc_code_o", enc_code_o, 0);
        check("R12 dec_valid_o", dec_valid_o, 0);
        check("R12 dec_sample_o", dec_sample_o, 0);

        // vector table
        for (int i = 0; i < 16; i++) begin
            enc_apply(VECS[i][22], VECS[i][21:8]);
            check("R1 enc_valid_o", enc_valid_o, 1);
            check($sformatf("R3-7 vec%0d", i), enc_code_o, VECS[i][7:0]);
        end

        // valid drops one cycle after strobe, data holds
        held = enc_code_o;
        enc_sample_i = 14'h1234;
        @(negedge clk);
        check("R1 enc_valid_o low", enc_valid_o, 0);
        check("R11 enc_code_o hold", enc_code_o, held);
        dec_apply(1'b1, 8'h80);
        dec_code_i = 8'h00;
        @(negedge clk);
        check("R1 dec_valid_o low", dec_valid_o, 0);
        check("R11 dec_sample_o hold", dec_sample_o, 14'h1F5F);

        // decoder directed midpoints
        dec_apply(1'b0, 8'hD5); check("R1 dec_valid_o", dec_valid_o, 1);
        check("R8 A D5", dec_sample_o, 14'h0002);
        dec_apply(1'b0, 8'h55); check("R8 A 55", dec_sample_o, 14'h3FFC);
        dec_apply(1'b0, 8'hAA); check("R8 A AA", dec_sample_o, 14'h1F80);
        dec_apply(1'b0, 8'h2A); check("R8 A 2A", dec_sample_o, 14'h207E);
        dec_apply(1'b1, 8'hFF); check("R9 mu FF", dec_sample_o, 14'h0000);
        dec_apply(1'b1, 8'h7F); check("R9 mu 7F", dec_sample_o, 14'h3FFF);
        dec_apply(1'b1, 8'h80); check("R9 mu 80", dec_sample_o, 14'h1F5F);
        dec_apply(1'b1, 8'h00); check("R9 mu 00", dec_sample_o, 14'h20A0);

        // exhaustive round trip, both laws
        for (int law = 0; law < 2; law++) begin
            for (int c = 0; c < 256; c++) begin
                dec_apply(law[0], c[7:0]);
                lin = dec_sample_o;
                enc_apply(law[0], lin);
                check($sformatf("R10 law%0d code%0h", law, c), enc_code_o, c[7:0]);
            end
        end

        finish_run();
    end

endmodule